// File: doc/BRIEF.md
# Oscillator Stabilization Wait Controller

After an oscillator has been stopped, its output is not usable at once: the resonator needs time before it settles on its natural frequency. This block keeps the CPU clock gated off for a chosen interval after each oscillator restart. It opens the gate only when that interval has passed. It has two independent paths. The main path runs on the main oscillator clock. The subclock path runs on the subclock.

On the main path, a restart is one of three things: the release of power-on reset, a return from main stop, or a request to move from subclock operation back to main clock operation. Each restart clears a timebase counter that runs on the newly started clock. The wait ends when one chosen bit of that counter first becomes 1. A 2-bit selector chooses which bit. The selector is sampled when the wait starts. On power-on the longest setting is always used. The subclock path works the same way, but its bit position is fixed. Its restart is the release of power-on reset or a return from sub-stop.

A halt strobe on either path closes the gate at once. The gate then stays closed until the next restart on that path.

Top module: `osw_ctrl`

## Requirements
- R1: While `rst_n` is low, `cpu_clk_en`, `main_ready`, `sub_clk_en` and `sub_ready` are all 0.
- R2: After `rst_n` rises, the main path starts a wait with selector value 3 (tap bit MAIN_BASE_BIT+3*MAIN_STEP), whatever `wait_sel` holds. `main_ready` appears after rising edge number SYNC_STAGES+1+2^(MAIN_BASE_BIT+3*MAIN_STEP) of `main_clk`, counted from the release.
- R3: A restart strobe (`main_stop_exit` or `sub_to_main`) samples `wait_sel` at the edge that captures it. Value s gives tap bit MAIN_BASE_BIT+MAIN_STEP*s. `cpu_clk_en` and `main_ready` rise exactly 2^tap edges after the capturing edge.
- R4: `cpu_clk_en` stays 0 for the whole of a wait.
- R5: `main_ready` is high for exactly one cycle, in the cycle in which `cpu_clk_en` rises.
- R6: Changes to `wait_sel` during a wait do not change the length of that wait.
- R7: A restart strobe during a wait clears the counter again. The interval is then counted from the new strobe, using the `wait_sel` value sampled with it.
- R8: `main_halt` drops `cpu_clk_en` at the next edge. The enable stays 0 until a later restart. If a halt and a restart arrive in the same cycle, the halt wins and no wait starts.
- R9: Once released, `cpu_clk_en` stays 1 and `main_ready` stays 0 while no strobe arrives, even when `wait_sel` changes.
- R10: The subclock path behaves the same way on `sub_clk`, with a fixed tap bit SUB_BIT. After a `sub_stop_exit` strobe, `sub_clk_en` and `sub_ready` rise 2^SUB_BIT edges after the capturing edge. After reset release they rise SYNC_STAGES+1+2^SUB_BIT edges after it. `sub_halt` drops `sub_clk_en`.
- R11: Strobes on one path have no effect on the enable of the other path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| main_clk | input | 1 | Main oscillator clock |
| sub_clk | input | 1 | Subclock oscillator clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| main_halt | input | 1 | Main oscillator is being stopped (main stop or switch to subclock) |
| main_stop_exit | input | 1 | Restart strobe: return from main stop |
| sub_to_main | input | 1 | Restart strobe: switch from subclock to main clock |
| wait_sel | input | 2 | Selector for the main wait interval |
| sub_halt | input | 1 | Subclock oscillator is being stopped (sub-stop entry) |
| sub_stop_exit | input | 1 | Restart strobe: return from sub-stop |
| cpu_clk_en | output | 1 | Gate enable for the CPU clock from the main path |
| main_ready | output | 1 | One-cycle pulse when the main wait ends |
| sub_clk_en | output | 1 | Gate enable from the subclock path |
| sub_ready | output | 1 | One-cycle pulse when the subclock wait ends |

## Verification
The main wait is tried with all four selector values, with both kinds of restart strobe. A mismatch in measured length therefore shows a wrong bit tap or a wrong sample of the selector, and not a defect tied to one strobe. Random trials also change the selector in the middle of a wait, which separates sampling at the start from following the live input. Other trials fire a second strobe in the middle of a wait, which separates a true counter clear from a wait that merely continues. Directed cases cover:
- the forced longest wait at power-on, with selector 0 applied;
- a halt that arrives together with a restart;
- the cross-path independence of the two enables.

// File: rtl/osw_pkg.sv
package osw_pkg;

  // Phase of one stabilization path.
  typedef enum logic [1:0] {
    OSW_OFF  = 2'd0,  // oscillator stopped, enable low
    OSW_WAIT = 2'd1,  // counting the stabilization interval
    OSW_RUN  = 2'd2   // interval elapsed, enable high
  } osw_phase_e;

endpackage

// File: rtl/osw_rst_sync.sv
module osw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  // Assertion is asynchronous; release ripples through the chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/osw_timebase.sv
module osw_timebase #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_inc_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign cnt_inc_o = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = cnt_inc_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/osw_wait_unit.sv
module osw_wait_unit
  import osw_pkg::*;
#(
  parameter  int CNT_W = 19,
  localparam int TAP_W = $clog2(CNT_W)
) (
  input  logic             clk,
  input  logic             rst_n,      // already synchronized
  input  logic             restart_i,
  input  logic             halt_i,
  input  logic [TAP_W-1:0] tap_req_i,  // tap used for an event-started wait
  input  logic [TAP_W-1:0] por_tap_i,  // tap used for the power-on wait
  output logic             clk_en_o,
  output logic             ready_o
);

  osw_phase_e       phase_q, phase_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             por_pend_q;
  logic             rdy_q, rdy_d;
  logic             start;
  logic             hit;
  logic             tb_clr;
  logic             tb_en;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;

  osw_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tb_clr),
    .en_i      (tb_en),
    .cnt_o     (cnt),
    .cnt_inc_o (cnt_inc)
  );

  // The wait ends when the latched tap bit first turns from 0 to 1.
  assign hit    = cnt_inc[tap_q] & ~cnt[tap_q];
  assign start  = por_pend_q | restart_i;
  assign tb_clr = start | halt_i;
  assign tb_en  = (phase_q == OSW_WAIT);

  always_comb begin
    phase_d = phase_q;
    tap_d   = tap_q;
    rdy_d   = 1'b0;
    if (halt_i) begin
      phase_d = OSW_OFF;
    end else if (start) begin
      phase_d = OSW_WAIT;
      tap_d   = por_pend_q ? por_tap_i : tap_req_i;
    end else if ((phase_q == OSW_WAIT) && hit) begin
      phase_d = OSW_RUN;
      rdy_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= OSW_OFF;
      tap_q      <= '0;
      por_pend_q <= 1'b1;
      rdy_q      <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      tap_q      <= tap_d;
      por_pend_q <= 1'b0;
      rdy_q      <= rdy_d;
    end
  end

  assign clk_en_o = (phase_q == OSW_RUN);
  assign ready_o  = rdy_q;

  AST_ENABLE_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_en_o) |-> ready_o); // R5
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o); // R5
  AST_READY_AT_TAP: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (cnt == (CNT_W'(1) << tap_q))); // R3
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !halt_i) |=> (!clk_en_o && (cnt == '0))); // R7
  AST_HALT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> !clk_en_o); // R8
  AST_TAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == OSW_WAIT) && !restart_i && !halt_i) |=> $stable(tap_q)); // R6

endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl #(
  parameter int MAIN_BASE_BIT = 12,
  parameter int MAIN_STEP     = 2,
  parameter int SUB_BIT       = 15,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       main_clk,
  input  logic       sub_clk,
  input  logic       rst_n,
  input  logic       main_halt,
  input  logic       main_stop_exit,
  input  logic       sub_to_main,
  input  logic [1:0] wait_sel,
  input  logic       sub_halt,
  input  logic       sub_stop_exit,
  output logic       cpu_clk_en,
  output logic       main_ready,
  output logic       sub_clk_en,
  output logic       sub_ready
);

  localparam int M_TOP_BIT = MAIN_BASE_BIT + 3 * MAIN_STEP;
  localparam int M_CNT_W   = M_TOP_BIT + 1;
  localparam int M_TAP_W   = $clog2(M_CNT_W);
  localparam int S_CNT_W   = SUB_BIT + 1;
  localparam int S_TAP_W   = $clog2(S_CNT_W);

  localparam logic [M_TAP_W-1:0] M_POR_TAP = M_TAP_W'(M_TOP_BIT);
  localparam logic [S_TAP_W-1:0] S_TAP     = S_TAP_W'(SUB_BIT);

  logic               main_rst_n;
  logic               sub_rst_n;
  logic               main_restart;
  logic [M_TAP_W-1:0] main_tap;

  function automatic logic [M_TAP_W-1:0] sel_to_tap(input logic [1:0] s);
    return M_TAP_W'(MAIN_BASE_BIT + MAIN_STEP * int'(s));
  endfunction

  osw_rst_sync #(.STAGES(SYNC_STAGES)) u_main_rst (
    .clk        (main_clk),
    .rst_n      (rst_n),
    .rst_sync_n (main_rst_n)
  );

  osw_rst_sync #(.STAGES(SYNC_STAGES)) u_sub_rst (
    .clk        (sub_clk),
    .rst_n      (rst_n),
    .rst_sync_n (sub_rst_n)
  );

  assign main_restart = main_stop_exit | sub_to_main;
  assign main_tap     = sel_to_tap(wait_sel);

  osw_wait_unit #(.CNT_W(M_CNT_W)) u_main (
    .clk       (main_clk),
    .rst_n     (main_rst_n),
    .restart_i (main_restart),
    .halt_i    (main_halt),
    .tap_req_i (main_tap),
    .por_tap_i (M_POR_TAP),
    .clk_en_o  (cpu_clk_en),
    .ready_o   (main_ready)
  );

  osw_wait_unit #(.CNT_W(S_CNT_W)) u_sub (
    .clk       (sub_clk),
    .rst_n     (sub_rst_n),
    .restart_i (sub_stop_exit),
    .halt_i    (sub_halt),
    .tap_req_i (S_TAP),
    .por_tap_i (S_TAP),
    .clk_en_o  (sub_clk_en),
    .ready_o   (sub_ready)
  );

endmodule

// File: tb/osw_ctrl_test.sv
module osw_ctrl_test;

  localparam int BASE = 3;
  localparam int STEP = 1;
  localparam int SUBB = 4;
  localparam int SYNC = 2;

  logic       main_clk = 1'b0;
  logic       sub_clk  = 1'b0;
  logic       rst_n;
  logic       main_halt, main_stop_exit, sub_to_main;
  logic [1:0] wait_sel;
  logic       sub_halt, sub_stop_exit;
  logic       cpu_clk_en, main_ready, sub_clk_en, sub_ready;

  int checks = 0;
  int errors = 0;

  always #10 main_clk = ~main_clk;  // 50 MHz
  always #30 sub_clk  = ~sub_clk;

  osw_ctrl #(
    .MAIN_BASE_BIT (BASE),
    .MAIN_STEP     (STEP),
    .SUB_BIT       (SUBB),
    .SYNC_STAGES   (SYNC)
  ) uut (
    .main_clk       (main_clk),
    .sub_clk        (sub_clk),
    .rst_n          (rst_n),
    .main_halt      (main_halt),
    .main_stop_exit (main_stop_exit),
    .sub_to_main    (sub_to_main),
    .wait_sel       (wait_sel),
    .sub_halt       (sub_halt),
    .sub_stop_exit  (sub_stop_exit),
    .cpu_clk_en     (cpu_clk_en),
    .main_ready     (main_ready),
    .sub_clk_en     (sub_clk_en),
    .sub_ready      (sub_ready)
  );

  function automatic int main_interval(input int sel);
    return 1 << (BASE + STEP * sel);
  endfunction

  function automatic int sub_interval();
    return 1 << SUBB;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Counts main edges from the capturing one until main_ready, clearing strobes.
  task automatic main_measure(input int exp_n, input int chg_at, input string req);
    int  n     = 0;
    bit  early = 1'b0;
    for (int i = 1; i <= exp_n + 8; i++) begin
      @(posedge main_clk); @(negedge main_clk);
      main_stop_exit = 1'b0; sub_to_main = 1'b0; main_halt = 1'b0;
      if (i == chg_at) wait_sel = 2'(wait_sel + 2'd1 + 2'($urandom % 3));
      if (main_ready) begin n = i; break; end
      if (cpu_clk_en) early = 1'b1;
    end
    check(n == exp_n, req, "main ready edge", n, exp_n);
    check(!early, "R4", "cpu_clk_en high during wait", int'(early), 0);
    check(cpu_clk_en, "R5", "cpu_clk_en with ready", int'(cpu_clk_en), 1);
    @(posedge main_clk); @(negedge main_clk);
    check(!main_ready && cpu_clk_en, "R5", "ready pulse width",
          int'(main_ready), 0);
  endtask

  task automatic sub_measure(input int exp_n, input string req);
    int n = 0;
    for (int i = 1; i <= exp_n + 8; i++) begin
      @(posedge sub_clk); @(negedge sub_clk);
      sub_stop_exit = 1'b0; sub_halt = 1'b0;
      if (sub_ready) begin n = i; break; end
    end
    check(n == exp_n && sub_clk_en, req, "sub ready edge", n, exp_n);
    @(posedge sub_clk); @(negedge sub_clk);
    check(!sub_ready && sub_clk_en, req, "sub ready pulse", int'(sub_ready), 0);
  endtask

  task automatic main_start(input bit kind, input logic [1:0] sel, input int chg_at,
                            input string req);
    @(negedge main_clk);
    wait_sel = sel;
    if (kind) sub_to_main = 1'b1; else main_stop_exit = 1'b1;
    main_measure(main_interval(int'(sel)) + 1, chg_at, req);
  endtask

  // Restart at cycle k of a running wait, with a new selector.
  task automatic main_restart(input logic [1:0] sel1, input int k,
                              input logic [1:0] sel2);
    bit early = 1'b0;
    @(negedge main_clk);
    wait_sel = sel1; main_stop_exit = 1'b1;
    for (int i = 1; i <= k; i++) begin
      @(posedge main_clk); @(negedge main_clk);
      main_stop_exit = 1'b0;
      if (main_ready || cpu_clk_en) early = 1'b1;
    end
    check(!early, "R7", "ended before restart", int'(early), 0);
    wait_sel = sel2; sub_to_main = 1'b1;
    main_measure(main_interval(int'(sel2)) + 1, 0, "R7");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    main_halt = 1'b0; main_stop_exit = 1'b0; sub_to_main = 1'b0;
    sub_halt = 1'b0; sub_stop_exit = 1'b0;
    wait_sel = 2'b00;
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (5) @(negedge main_clk);
    check(!cpu_clk_en && !main_ready && !sub_clk_en && !sub_ready, "R1",
          "outputs in reset",
          int'({cpu_clk_en, main_ready, sub_clk_en, sub_ready}), 0);

    // R2 / R10: power-on waits, selector held at 0
    rst_n = 1'b1;
    fork
      main_measure(SYNC + 1 + main_interval(3), 0, "R2");
      sub_measure(SYNC + 1 + sub_interval(), "R10");
    join

    // R3: every selector with both strobe kinds
    for (int s = 0; s < 4; s++) begin
      main_start(1'b0, 2'(s), 0, "R3");
      main_start(1'b1, 2'(s), 0, "R3");
    end

    // R9: selector changes while running
    begin
      bit bad = 1'b0;
      for (int i = 0; i < 20; i++) begin
        @(negedge main_clk);
        wait_sel = 2'($urandom);
        if (!cpu_clk_en || main_ready) bad = 1'b1;
      end
      check(!bad, "R9", "run state disturbed", int'(bad), 0);
    end

    // R8: halt, then halt together with restart
    @(negedge main_clk); main_halt = 1'b1;
    @(posedge main_clk); @(negedge main_clk); main_halt = 1'b0;
    check(!cpu_clk_en, "R8", "enable after halt", int'(cpu_clk_en), 0);
    begin
      bit rose = 1'b0;
      main_halt = 1'b1; main_stop_exit = 1'b1; wait_sel = 2'b00;
      @(posedge main_clk); @(negedge main_clk);
      main_halt = 1'b0; main_stop_exit = 1'b0;
      for (int i = 0; i < main_interval(3) + 6; i++) begin
        @(negedge main_clk);
        if (cpu_clk_en || main_ready) rose = 1'b1;
      end
      check(!rose, "R8", "wait started despite halt", int'(rose), 0);
    end

    // R6 directed: selector bumped inside the longest wait
    main_start(1'b0, 2'b11, 5, "R6");
    // R7 directed: restart late in a short wait, switching to a long one
    main_restart(2'b00, main_interval(0), 2'b10);

    // Random mix
    for (int t = 0; t < 16; t++) begin
      logic [1:0] s    = 2'($urandom);
      int         mode = int'($urandom % 3);
      int         iv   = main_interval(int'(s));
      if (mode == 0) main_start(1'($urandom), s, 0, "R3");
      else if (mode == 1) main_start(1'($urandom), s, 2 + int'($urandom % (iv - 1)), "R6");
      else main_restart(s, 2 + int'($urandom % (iv - 1)), 2'($urandom));
    end

    // R10: sub-stop exit and sub halt
    @(negedge sub_clk); sub_stop_exit = 1'b1;
    sub_measure(sub_interval() + 1, "R10");

    // R11: main strobes leave the sub enable alone
    begin
      bit bad = 1'b0;
      @(negedge main_clk); main_stop_exit = 1'b1;
      @(negedge main_clk); main_stop_exit = 1'b0; main_halt = 1'b1;
      @(negedge main_clk); main_halt = 1'b0;
      repeat (4) @(negedge sub_clk);
      if (!sub_clk_en) bad = 1'b1;
      check(!bad, "R11", "sub enable after main strobes", int'(sub_clk_en), 1);
    end
    main_start(1'b1, 2'b01, 0, "R3");
    @(negedge sub_clk); sub_halt = 1'b1;
    @(posedge sub_clk); @(negedge sub_clk); sub_halt = 1'b0;
    check(!sub_clk_en, "R10", "sub enable after halt", int'(sub_clk_en), 0);
    repeat (3) @(negedge main_clk);
    check(cpu_clk_en, "R11", "main enable after sub halt", int'(cpu_clk_en), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule